// File: doc/BRIEF.md
# Integer Multiply/Divide Timing Unit

This block is the integer multiply and divide engine that sits beside a processor's main ALU. It owns two 64-bit result registers, HI and LO. It accepts signed and unsigned 32-bit and 64-bit multiplies, 32-bit and 64-bit divides, and 32-bit multiply-accumulate operations that either add the product into HI/LO or subtract it. Each operation class has its own result latency and its own repeat interval. The latency is the number of clock edges from acceptance until the result appears in HI/LO. The repeat interval is the number of edges from acceptance until the next operation can be accepted.

The product or quotient is formed when the operation is accepted and held in a small in-flight slot. A countdown releases it into HI/LO on the exact edge the latency requires. Accumulate operations combine their product with the HI/LO contents at that release edge, so back-to-back accumulates chain correctly even though their windows overlap.

A stall output tells the surrounding pipeline to wait in two cases: when it wants to read HI/LO while any operation is still in flight, or when it offers a new operation inside the current repeat window. A slow-multiply strap is captured while reset is held. When it is set, every multiply-class operation takes one extra cycle of latency and one extra cycle of repeat interval.

Top module: `imd_unit`

## Requirements
- R1: While reset is held and on the first cycle after it, HI and LO read zero, `op_ready_o` is 1 and `stall_o` is 0.
- R2: Codes 0 (signed) and 1 (unsigned) multiply the low 32 bits of A and B. LO becomes the sign-extended low 32 bits of the 64-bit product and HI becomes the sign-extended high 32 bits. The result appears 4 edges after acceptance and the next accept is possible 3 edges after it.
- R3: Codes 2 (signed) and 3 (unsigned) form the 128-bit product of A and B. LO gets bits 63:0 and HI gets bits 127:64. Latency is 6 and repeat is 5.
- R4: Codes 4 (signed) and 5 (unsigned) divide the low 32 bits of A by those of B, truncating toward zero. LO gets the sign-extended quotient and HI gets the sign-extended remainder. Latency and repeat are both 36.
- R5: Codes 6 (signed) and 7 (unsigned) divide the 64-bit A by B. LO gets the quotient and HI gets the remainder. Latency and repeat are both 68.
- R6: A zero divisor raises no error and keeps the normal timing. The quotient is all ones at the operation width and the remainder equals the dividend (both sign-extended for 32-bit divides).
- R7: Codes 8 (signed) and 9 (unsigned) add the 64-bit product of the low 32 bits to {HI[31:0], LO[31:0]}. The sum's halves are then written back sign-extended into HI and LO. Latency is 3 and repeat is 2. Overlapping accumulates see each other's results in issue order.
- R8: Codes 10 (signed) and 11 (unsigned) do the same as codes 8 and 9 but subtract the product. Latency is 4 and repeat is 3.
- R9: The slow-multiply input is sampled only while reset is held. When it was 1, codes 0–3 and 8–11 each take one more cycle of latency and of repeat interval, while divides keep their timing. Changing the input after reset has no effect.
- R10: `op_ready_o` is 0 during the repeat window. A valid operation offered while not ready is not taken and drives `stall_o` to 1.
- R11: `stall_o` is 1 when `hilo_rd_i` is asserted while any accepted operation has not yet reached HI/LO, and 0 for a read once all results have landed.
- R12: Codes 12 to 15 are never accepted. They leave HI, LO and the repeat window unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_mul_i | input | 1 | Slow-multiply strap, captured during reset |
| op_valid_i | input | 1 | An operation is offered this cycle |
| op_code_i | input | 4 | Operation code (see R2–R8, R12) |
| op_a_i | input | 64 | First operand (dividend, multiplicand) |
| op_b_i | input | 64 | Second operand (divisor, multiplier) |
| hilo_rd_i | input | 1 | The pipeline wants to read HI/LO this cycle |
| op_ready_o | output | 1 | An offered legal operation is taken at the next edge |
| stall_o | output | 1 | The pipeline must hold this cycle |
| hi_o | output | 64 | HI result register |
| lo_o | output | 64 | LO result register |

## Verification
The bench builds the unit with its default timing parameters: 4/3, 6/5, 36/36, 68/68, 3/2 and 4/3 cycles, with two in-flight slots. Under these values the full 68-cycle divide window and the chained multiply-accumulates, whose latency exceeds their repeat interval, can both be observed. A second reset with the slow strap set covers the lengthened multiply timings against unchanged divide timings. The reference model predicts `op_ready_o`, `stall_o`, HI and LO on every clock.

// File: rtl/imd_pkg.sv
package imd_pkg;

    localparam int XLEN = 64;
    localparam int HALF = XLEN / 2;
    localparam int OPW  = 4;

    localparam logic [OPW-1:0] OP_MUL32S = OPW'(0);
    localparam logic [OPW-1:0] OP_MUL32U = OPW'(1);
    localparam logic [OPW-1:0] OP_MUL64S = OPW'(2);
    localparam logic [OPW-1:0] OP_MUL64U = OPW'(3);
    localparam logic [OPW-1:0] OP_DIV32S = OPW'(4);
    localparam logic [OPW-1:0] OP_DIV32U = OPW'(5);
    localparam logic [OPW-1:0] OP_DIV64S = OPW'(6);
    localparam logic [OPW-1:0] OP_DIV64U = OPW'(7);
    localparam logic [OPW-1:0] OP_MACS   = OPW'(8);
    localparam logic [OPW-1:0] OP_MACU   = OPW'(9);
    localparam logic [OPW-1:0] OP_MSBS   = OPW'(10);
    localparam logic [OPW-1:0] OP_MSBU   = OPW'(11);

    localparam logic [1:0] KIND_LOAD = 2'd0;
    localparam logic [1:0] KIND_ADD  = 2'd1;
    localparam logic [1:0] KIND_SUB  = 2'd2;

    function automatic logic [XLEN-1:0] sext_half(input logic [HALF-1:0] v);
        return {{HALF{v[HALF-1]}}, v};
    endfunction

    function automatic logic is_mul_class(input logic [OPW-1:0] op);
        return (op == OP_MUL32S) || (op == OP_MUL32U) ||
               (op == OP_MUL64S) || (op == OP_MUL64U) ||
               (op == OP_MACS)   || (op == OP_MACU)   ||
               (op == OP_MSBS)   || (op == OP_MSBU);
    endfunction

endpackage

// File: rtl/imd_arith.sv
module imd_arith
    import imd_pkg::*;
(
    input  logic [OPW-1:0]  op_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    output logic            legal_o,
    output logic [1:0]      kind_o,
    output logic [XLEN-1:0] hi_o,
    output logic [XLEN-1:0] lo_o
);

    logic [HALF-1:0]   a_h, b_h;
    logic              sgn;
    logic [XLEN-1:0]   p_half_s, p_half_u, p_half;
    logic [2*XLEN-1:0] p_full_s, p_full_u, p_full;
    logic [HALF-1:0]   q_h, r_h;
    logic [XLEN-1:0]   q_f, r_f;

    assign a_h = a_i[HALF-1:0];
    assign b_h = b_i[HALF-1:0];
    // even codes are the signed flavour of each pair
    assign sgn = ~op_i[0];

    // products
    always_comb begin
        p_half_s = $signed(sext_half(a_h)) * $signed(sext_half(b_h));
        p_half_u = {{HALF{1'b0}}, a_h} * {{HALF{1'b0}}, b_h};
        p_half   = sgn ? p_half_s : p_half_u;
        p_full_s = $signed({{XLEN{a_i[XLEN-1]}}, a_i}) * $signed({{XLEN{b_i[XLEN-1]}}, b_i});
        p_full_u = {{XLEN{1'b0}}, a_i} * {{XLEN{1'b0}}, b_i};
        p_full   = sgn ? p_full_s : p_full_u;
    end

    // half-width quotient and remainder, zero divisor defined
    always_comb begin
        if (b_h == '0) begin
            q_h = '1;
            r_h = a_h;
        end else if (sgn) begin
            q_h = $signed(a_h) / $signed(b_h);
            r_h = $signed(a_h) % $signed(b_h);
        end else begin
            q_h = a_h / b_h;
            r_h = a_h % b_h;
        end
    end

    // full-width quotient and remainder
    always_comb begin
        if (b_i == '0) begin
            q_f = '1;
            r_f = a_i;
        end else if (sgn) begin
            q_f = $signed(a_i) / $signed(b_i);
            r_f = $signed(a_i) % $signed(b_i);
        end else begin
            q_f = a_i / b_i;
            r_f = a_i % b_i;
        end
    end

    always_comb begin
        legal_o = 1'b1;
        kind_o  = KIND_LOAD;
        hi_o    = '0;
        lo_o    = '0;
        case (op_i)
            OP_MUL32S, OP_MUL32U: begin
                hi_o = sext_half(p_half[XLEN-1:HALF]);
                lo_o = sext_half(p_half[HALF-1:0]);
            end
            OP_MUL64S, OP_MUL64U: begin
                hi_o = p_full[2*XLEN-1:XLEN];
                lo_o = p_full[XLEN-1:0];
            end
            OP_DIV32S, OP_DIV32U: begin
                hi_o = sext_half(r_h);
                lo_o = sext_half(q_h);
            end
            OP_DIV64S, OP_DIV64U: begin
                hi_o = r_f;
                lo_o = q_f;
            end
            OP_MACS, OP_MACU: begin
                kind_o = KIND_ADD;
                lo_o   = p_half;
            end
            OP_MSBS, OP_MSBU: begin
                kind_o = KIND_SUB;
                lo_o   = p_half;
            end
            default: legal_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/imd_timing.sv
module imd_timing
    import imd_pkg::*;
#(
    parameter int CNT_W     = 7,
    parameter int LAT_MUL32 = 4,
    parameter int REP_MUL32 = 3,
    parameter int LAT_MUL64 = 6,
    parameter int REP_MUL64 = 5,
    parameter int LAT_DIV32 = 36,
    parameter int REP_DIV32 = 36,
    parameter int LAT_DIV64 = 68,
    parameter int REP_DIV64 = 68,
    parameter int LAT_MAC   = 3,
    parameter int REP_MAC   = 2,
    parameter int LAT_MSB   = 4,
    parameter int REP_MSB   = 3
) (
    input  logic [OPW-1:0]   op_i,
    input  logic             slow_i,
    output logic [CNT_W-1:0] lat_o,
    output logic [CNT_W-1:0] rep_o
);

    logic [CNT_W-1:0] lat_base, rep_base, extra;

    always_comb begin
        case (op_i)
            OP_MUL32S, OP_MUL32U: begin lat_base = CNT_W'(LAT_MUL32); rep_base = CNT_W'(REP_MUL32); end
            OP_MUL64S, OP_MUL64U: begin lat_base = CNT_W'(LAT_MUL64); rep_base = CNT_W'(REP_MUL64); end
            OP_DIV32S, OP_DIV32U: begin lat_base = CNT_W'(LAT_DIV32); rep_base = CNT_W'(REP_DIV32); end
            OP_DIV64S, OP_DIV64U: begin lat_base = CNT_W'(LAT_DIV64); rep_base = CNT_W'(REP_DIV64); end
            OP_MACS,   OP_MACU:   begin lat_base = CNT_W'(LAT_MAC);   rep_base = CNT_W'(REP_MAC);   end
            OP_MSBS,   OP_MSBU:   begin lat_base = CNT_W'(LAT_MSB);   rep_base = CNT_W'(REP_MSB);   end
            default:              begin lat_base = CNT_W'(1);         rep_base = CNT_W'(1);         end
        endcase
        extra = CNT_W'(slow_i && is_mul_class(op_i));
        lat_o = lat_base + extra;
        rep_o = rep_base + extra;
    end

endmodule

// File: rtl/imd_unit.sv
module imd_unit
    import imd_pkg::*;
#(
    parameter int LAT_MUL32 = 4,
    parameter int REP_MUL32 = 3,
    parameter int LAT_MUL64 = 6,
    parameter int REP_MUL64 = 5,
    parameter int LAT_DIV32 = 36,
    parameter int REP_DIV32 = 36,
    parameter int LAT_DIV64 = 68,
    parameter int REP_DIV64 = 68,
    parameter int LAT_MAC   = 3,
    parameter int REP_MAC   = 2,
    parameter int LAT_MSB   = 4,
    parameter int REP_MSB   = 3,
    parameter int NSLOT     = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            slow_mul_i,
    input  logic            op_valid_i,
    input  logic [3:0]      op_code_i,
    input  logic [63:0]     op_a_i,
    input  logic [63:0]     op_b_i,
    input  logic            hilo_rd_i,
    output logic            op_ready_o,
    output logic            stall_o,
    output logic [63:0]     hi_o,
    output logic [63:0]     lo_o
);

    localparam int CNT_W = $clog2(LAT_DIV64 + 2);

    typedef struct packed {
        logic             vld;
        logic [CNT_W-1:0] cnt;
        logic [1:0]       kind;
        logic [XLEN-1:0]  hi;
        logic [XLEN-1:0]  lo;
    } slot_t;

    typedef struct packed {
        logic                   slow;
        logic [CNT_W-1:0]       rep;
        slot_t [NSLOT-1:0]      slot;
        logic [XLEN-1:0]        hi;
        logic [XLEN-1:0]        lo;
    } state_t;

    state_t state_d, state_q;

    logic             legal;
    logic [1:0]       kind;
    logic [XLEN-1:0]  res_hi, res_lo;
    logic [CNT_W-1:0] lat, rep;
    logic             ready, accept, pending, placed;
    logic [NSLOT-1:0] commit_v;
    logic [XLEN-1:0]  acc;

    imd_arith u_arith (
        .op_i    (op_code_i),
        .a_i     (op_a_i),
        .b_i     (op_b_i),
        .legal_o (legal),
        .kind_o  (kind),
        .hi_o    (res_hi),
        .lo_o    (res_lo)
    );

    imd_timing #(
        .CNT_W     (CNT_W),
        .LAT_MUL32 (LAT_MUL32), .REP_MUL32 (REP_MUL32),
        .LAT_MUL64 (LAT_MUL64), .REP_MUL64 (REP_MUL64),
        .LAT_DIV32 (LAT_DIV32), .REP_DIV32 (REP_DIV32),
        .LAT_DIV64 (LAT_DIV64), .REP_DIV64 (REP_DIV64),
        .LAT_MAC   (LAT_MAC),   .REP_MAC   (REP_MAC),
        .LAT_MSB   (LAT_MSB),   .REP_MSB   (REP_MSB)
    ) u_timing (
        .op_i   (op_code_i),
        .slow_i (state_q.slow),
        .lat_o  (lat),
        .rep_o  (rep)
    );

    always_comb begin
        state_d  = state_q;
        commit_v = '0;
        acc      = '0;
        placed   = 1'b0;
        pending  = 1'b0;
        for (int i = 0; i < NSLOT; i++) begin
            pending = pending | state_q.slot[i].vld;
        end
        ready  = (state_q.rep == '0);
        accept = op_valid_i && ready && legal;

        // repeat window
        if (accept) begin
            state_d.rep = rep - CNT_W'(1);
        end else if (state_q.rep != '0) begin
            state_d.rep = state_q.rep - CNT_W'(1);
        end

        // countdown and release into HI/LO
        for (int i = 0; i < NSLOT; i++) begin
            if (state_q.slot[i].vld) begin
                if (state_q.slot[i].cnt == '0) begin
                    commit_v[i]           = 1'b1;
                    state_d.slot[i].vld   = 1'b0;
                    case (state_q.slot[i].kind)
                        KIND_ADD: begin
                            acc = {state_q.hi[HALF-1:0], state_q.lo[HALF-1:0]} + state_q.slot[i].lo;
                            state_d.hi = sext_half(acc[XLEN-1:HALF]);
                            state_d.lo = sext_half(acc[HALF-1:0]);
                        end
                        KIND_SUB: begin
                            acc = {state_q.hi[HALF-1:0], state_q.lo[HALF-1:0]} - state_q.slot[i].lo;
                            state_d.hi = sext_half(acc[XLEN-1:HALF]);
                            state_d.lo = sext_half(acc[HALF-1:0]);
                        end
                        default: begin
                            state_d.hi = state_q.slot[i].hi;
                            state_d.lo = state_q.slot[i].lo;
                        end
                    endcase
                end else begin
                    state_d.slot[i].cnt = state_q.slot[i].cnt - CNT_W'(1);
                end
            end
        end

        // place a newly accepted operation into the first free slot
        for (int i = 0; i < NSLOT; i++) begin
            if (accept && !placed && !state_q.slot[i].vld) begin
                state_d.slot[i].vld  = 1'b1;
                state_d.slot[i].cnt  = lat - CNT_W'(1);
                state_d.slot[i].kind = kind;
                state_d.slot[i].hi   = res_hi;
                state_d.slot[i].lo   = res_lo;
                placed               = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= '0;
            state_q.slow <= slow_mul_i;
        end else begin
            state_q <= state_d;
        end
    end

    assign op_ready_o = ready;
    assign stall_o    = (hilo_rd_i && pending) || (op_valid_i && !ready);
    assign hi_o       = state_q.hi;
    assign lo_o       = state_q.lo;

    // assertions
    AST_HILO_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !pending |=> ($stable(hi_o) && $stable(lo_o)));                       // R2
    AST_REPEAT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && op_ready_o && legal) |=> !op_ready_o);                  // R10
    AST_SLOT_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> !(&commit_v) && ($countones(commit_v) + 32'(pending) <= NSLOT)); // R10
    AST_SINGLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(commit_v) <= 1);                                            // R7
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(state_q.slow));                                                // R9
    AST_ILLEGAL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && !legal && op_ready_o) |=> op_ready_o);                  // R12

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot_chk
        AST_SLOT_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
            (state_q.slot[g].vld && state_q.slot[g].cnt != '0) |=> state_q.slot[g].vld); // R2
    end

endmodule

// File: tb/imd_unit_bench.sv
module imd_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_mul = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic        hilo_rd = 1'b0;
    logic        op_ready_o, stall_o;
    logic [63:0] hi_o, lo_o;

    always #4 clk = ~clk;

    imd_unit u_imd_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .slow_mul_i (slow_mul),
        .op_valid_i (op_valid),
        .op_code_i  (op_code),
        .op_a_i     (op_a),
        .op_b_i     (op_b),
        .hilo_rd_i  (hilo_rd),
        .op_ready_o (op_ready_o),
        .stall_o    (stall_o),
        .hi_o       (hi_o),
        .lo_o       (lo_o)
    );

    typedef struct {
        int          at;
        int          kind;
        logic [63:0] hi;
        logic [63:0] lo;
    } ev_t;

    ev_t         evq[$];
    int          errs = 0;
    int          checks = 0;
    int          edges = 0;
    int          ready_edge = 0;
    bit          slow_m = 1'b0;
    logic [63:0] m_hi = '0;
    logic [63:0] m_lo = '0;

    function automatic logic [63:0] sx(input logic [31:0] v);
        return {{32{v[31]}}, v};
    endfunction

    task automatic chk64(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s act=%h exp=%h at edge %0d", tag, what, act, exp, edges);
        end
    endtask

    task automatic chk1(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s act=%b exp=%b at edge %0d", tag, what, act, exp, edges);
        end
    endtask

    // behavioural model of one operation
    function automatic void model(input logic [3:0] op, input logic [63:0] a, input logic [63:0] b,
                                  input bit slow, output bit legal, output int kind,
                                  output logic [63:0] hi, output logic [63:0] lo,
                                  output int lat, output int rep);
        int                  sa, sb, sq, sr;
        int unsigned         ua, ub, uq, ur;
        longint              la, lb, lq, lr;
        longint unsigned     lua, lub, luq, lur;
        logic signed [127:0] xa, xb, ps;
        logic [127:0]        pu;
        logic [63:0]         p;
        bit                  mulc;
        legal = 1'b1; kind = 0; hi = '0; lo = '0; lat = 1; rep = 1; mulc = 1'b1;
        sa = a[31:0]; sb = b[31:0]; ua = a[31:0]; ub = b[31:0];
        la = a; lb = b; lua = a; lub = b;
        if (op[0] == 1'b0) p = longint'(sa) * longint'(sb);
        else               p = {32'b0, a[31:0]} * {32'b0, b[31:0]};
        case (op)
            4'd0, 4'd1: begin hi = sx(p[63:32]); lo = sx(p[31:0]); lat = 4; rep = 3; end
            4'd2: begin
                xa = {{64{a[63]}}, a}; xb = {{64{b[63]}}, b}; ps = xa * xb;
                hi = ps[127:64]; lo = ps[63:0]; lat = 6; rep = 5;
            end
            4'd3: begin pu = {64'b0, a} * {64'b0, b}; hi = pu[127:64]; lo = pu[63:0]; lat = 6; rep = 5; end
            4'd4: begin
                if (sb == 0) begin sq = -1; sr = sa; end else begin sq = sa / sb; sr = sa % sb; end
                hi = sx(sr); lo = sx(sq); lat = 36; rep = 36; mulc = 1'b0;
            end
            4'd5: begin
                if (ub == 0) begin uq = 32'hFFFF_FFFF; ur = ua; end else begin uq = ua / ub; ur = ua % ub; end
                hi = sx(ur); lo = sx(uq); lat = 36; rep = 36; mulc = 1'b0;
            end
            4'd6: begin
                if (lb == 0) begin lq = -1; lr = la; end else begin lq = la / lb; lr = la % lb; end
                hi = lr; lo = lq; lat = 68; rep = 68; mulc = 1'b0;
            end
            4'd7: begin
                if (lub == 0) begin luq = '1; lur = lua; end else begin luq = lua / lub; lur = lua % lub; end
                hi = lur; lo = luq; lat = 68; rep = 68; mulc = 1'b0;
            end
            4'd8, 4'd9:   begin kind = 1; lo = p; lat = 3; rep = 2; end
            4'd10, 4'd11: begin kind = 2; lo = p; lat = 4; rep = 3; end
            default: begin legal = 1'b0; mulc = 1'b0; end
        endcase
        if (slow && mulc) begin lat++; rep++; end
    endfunction

    // one clock: drive at negedge, check ready/stall, then check HI/LO after the edge
    task automatic cyc(input bit v, input logic [3:0] op, input logic [63:0] a, input logic [63:0] b,
                       input bit rd, input string tag, output bit acc);
        bit          exp_ready, pend, legal;
        int          kind, lat, rep;
        logic [63:0] rh, rl, s;
        ev_t         e;
        op_valid = v; op_code = op; op_a = a; op_b = b; hilo_rd = rd;
        #1;
        exp_ready = (edges + 1 >= ready_edge);
        pend      = (evq.size() != 0);
        chk1(tag, "ready", op_ready_o, exp_ready);
        chk1(tag, "stall", stall_o, (rd && pend) || (v && !exp_ready));
        model(op, a, b, slow_m, legal, kind, rh, rl, lat, rep);
        acc = v && exp_ready && legal;
        if (acc) begin
            e.at = edges + 1 + lat; e.kind = kind; e.hi = rh; e.lo = rl;
            evq.push_back(e);
            ready_edge = edges + 1 + rep;
        end
        @(posedge clk);
        edges++;
        for (int i = 0; i < evq.size(); i++) begin
            if (evq[i].at == edges) begin
                if (evq[i].kind == 0) begin
                    m_hi = evq[i].hi; m_lo = evq[i].lo;
                end else begin
                    s = {m_hi[31:0], m_lo[31:0]};
                    s = (evq[i].kind == 1) ? s + evq[i].lo : s - evq[i].lo;
                    m_hi = sx(s[63:32]); m_lo = sx(s[31:0]);
                end
                evq.delete(i);
                break;
            end
        end
        @(negedge clk);
        chk64(tag, "hi", hi_o, m_hi);
        chk64(tag, "lo", lo_o, m_lo);
    endtask

    task automatic issue(input logic [3:0] op, input logic [63:0] a, input logic [63:0] b, input string tag);
        bit acc = 1'b0;
        while (!acc) cyc(1'b1, op, a, b, 1'b0, tag, acc);
    endtask

    task automatic idle(input int n, input bit rd, input string tag);
        bit acc;
        for (int i = 0; i < n; i++) cyc(1'b0, 4'd0, '0, '0, rd, tag, acc);
    endtask

    task automatic drain(input string tag);
        bit acc;
        while (evq.size() != 0 || edges + 1 < ready_edge) cyc(1'b0, 4'd0, '0, '0, 1'b1, tag, acc);
        cyc(1'b0, 4'd0, '0, '0, 1'b1, tag, acc);
    endtask

    task automatic do_reset(input bit s);
        rst_n = 1'b0; slow_mul = s; op_valid = 1'b0; hilo_rd = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        evq.delete(); edges = 0; ready_edge = 0; slow_m = s; m_hi = '0; m_lo = '0;
        #1;
        chk64("R1", "hi", hi_o, '0);
        chk64("R1", "lo", lo_o, '0);
        chk1("R1", "ready", op_ready_o, 1'b1);
        chk1("R1", "stall", stall_o, 1'b0);
        slow_mul = ~s;   // R9: strap changes after reset must not matter
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        bit acc;
        @(negedge clk);
        do_reset(1'b0);

        // R2 and R10: back-to-back 32-bit multiplies
        issue(4'd0, 64'hFFFF_FFFF_FFFF_FFFD, 64'd7, "R2");
        issue(4'd1, 64'h0000_0000_FFFF_FFFF, 64'd2, "R10");
        idle(5, 1'b1, "R11");

        // R3
        issue(4'd2, 64'hFFFF_FFFF_FFFF_FFFB, 64'h1234_5678_9ABC_DEF0, "R3");
        issue(4'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, "R3");
        drain("R11");

        // R7 chained accumulates, then R8
        issue(4'd1, '0, '0, "R7");
        issue(4'd8, 64'd1000, 64'hFFFF_FFFF_FFFF_FFFD, "R7");
        issue(4'd8, 64'd1000, 64'hFFFF_FFFF_FFFF_FFFD, "R7");
        issue(4'd9, 64'hFFFF_FFFF, 64'hFFFF_FFFF, "R7");
        issue(4'd10, 64'd12345, 64'd678, "R8");
        issue(4'd11, 64'h8000_0000, 64'h4, "R8");
        drain("R8");

        // R4, R5
        issue(4'd4, 64'hFFFF_FFFF_FFFF_FF9C, 64'd7, "R4");
        issue(4'd5, 64'h0000_0000_FFFF_FFF0, 64'd16, "R4");
        idle(20, 1'b1, "R11");
        issue(4'd6, 64'hFFFF_FF17_2B5A_F000, 64'd37, "R5");
        issue(4'd7, 64'hFEDC_BA98_7654_3210, 64'h0000_0001_0000_0003, "R5");
        drain("R5");

        // R6: zero divisors
        issue(4'd4, 64'h0000_0000_8000_007B, 64'hFFFF_FFFF_0000_0000, "R6");
        issue(4'd7, 64'h1234_0000_0000_5678, 64'd0, "R6");
        drain("R6");

        // R12: unused codes offered while ready
        cyc(1'b1, 4'd13, 64'd5, 64'd5, 1'b0, "R12", acc);
        cyc(1'b1, 4'd15, 64'd9, 64'd9, 1'b1, "R12", acc);
        cyc(1'b1, 4'd12, 64'd1, 64'd1, 1'b0, "R12", acc);
        idle(2, 1'b1, "R12");

        // R9: slow strap
        do_reset(1'b1);
        issue(4'd0, 64'd77, 64'hFFFF_FFFF_FFFF_FFF6, "R9");
        issue(4'd8, 64'd3, 64'd4, "R9");
        issue(4'd10, 64'd5, 64'd6, "R9");
        issue(4'd2, 64'h7FFF_FFFF_FFFF_FFFF, 64'd3, "R9");
        issue(4'd5, 64'd100, 64'd9, "R9");
        drain("R9");

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule